// File: doc/BRIEF.md
# Mode-Table SPI Flash Command Sequencer

This block is a host-side SPI master. It runs one complete serial-flash transaction from a small window of byte-wide registers. The host fills in an opcode, the low address bytes and any write data. It then writes a single mode byte. The upper nibble of that byte picks one of eleven fixed frame layouts. The lower nibble supplies address bits 19:16. Writing the mode byte also starts the transfer.

Once started, the sequencer drives chip select low. It shifts out the opcode, the address, an optional internally generated dummy byte and any write data, most significant bit first, in SPI mode 0. During read layouts it captures the returned bytes into the data registers. It then releases chip select. The host polls a busy flag and afterwards reads the captured bytes. Only 20 address bits reach the flash, and the top address nibble on the wire is always zero.

Top module: `spiFlashSeq`

## Requirements
- R1: After reset, spiCsN is high, spiSck is low, and every register offset reads 0x00.
- R2: When idle, a host write to offset 0 (opcode), offset 2 (address bits 15:8), offset 3 (address bits 7:0) or offsets 4 to 7 (data bytes 0 to 3) reads back unchanged. Offset 1 reads {busy, 3'b000, address bits 19:16}.
- R3: Writing offset 1 while idle with a code in bits 7:4 from 1 to 11 latches bits 3:0 as address bits 19:16, starts a frame and pulls spiCsN low at the next clock edge.
- R4: Writing offset 1 with code 0 or with a code from 12 to 15 starts no frame and leaves the offset-1 readback unchanged.
- R5: While busy, every host register write is ignored. This covers the mode byte (no second frame starts) and the data bytes.
- R6: The bytes on spiMosi follow the selected layout: the opcode; then, for codes 4 to 11, the address as {4'h0, bits 19:16}, bits 15:8, bits 7:0; then, for code 7 only, one 0x00 dummy byte; then the write bytes taken from data byte 0 upward (code 2: one, code 5: one, code 6: four); then 0x00 for every read byte (code 3: two, code 7: four, codes 8 to 11: one to four).
- R7: SPI mode 0 with the most significant bit first. spiSck idles low and rises only while spiCsN is low. spiMosi changes only on falling SCK. spiMiso is sampled on rising SCK.
- R8: In read layouts the k-th received data byte is stored in data byte k (offset 4+k). Data bytes that the layout does not read keep their values.
- R9: Each SCK half period lasts sckDiv+1 clocks. For a frame of N bytes, busy stays high, and spiCsN low, for exactly (16N+1)(sckDiv+1) clocks. The longest 9-byte frame at sckDiv=0 therefore takes 145 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckDiv | input | 4 | SCK half-period minus one, in clocks; captured at frame start |
| hostWe | input | 1 | Register write strobe |
| hostAddr | input | 3 | Register offset for reads and writes |
| hostWdata | input | 8 | Register write data |
| hostRdata | output | 8 | Register read data for hostAddr (combinational) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the host drives hostWe, hostAddr and hostWdata as clean synchronous signals that change away from the clock edge. They also assume that spiMiso is stable around each rising SCK. The bench keeps to this by changing host inputs only after falling clock edges. Its flash model updates spiMiso only after a rising SCK has been taken, so the value is stable for a full half period before the next sample. The random frames draw codes, divider values, addresses and flash response bytes from a seeded generator. Directed cases cover every code, the longest frame, the illegal codes and host writes during a transfer.

// File: rtl/spiSeqPkg.sv
package spiSeqPkg;

  typedef enum logic [2:0] {
    SRC_OPC, SRC_AHI, SRC_AMID, SRC_ALO, SRC_ZERO, SRC_DATA
  } byteSrcT;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} seqStateT;

  // one decoded frame layout
  typedef struct packed {
    logic       valid;
    logic       hasAddr;
    logic       dummy;
    logic [2:0] nWr;
    logic [2:0] nRd;
  } frameT;

  // what goes on the wire in one byte slot
  typedef struct packed {
    byteSrcT    src;
    logic [1:0] idx;
    logic       isRead;
  } byteSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic       launch;
    logic       load;
    byteSrcT    src;
    logic [1:0] dataIdx;
    logic       sample;
    logic       shift;
    logic       store;
    logic [1:0] storeIdx;
  } dpCtrlT;

  function automatic frameT decodeMode(input logic [3:0] code);
    frameT f;
    f = '0;
    f.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: f.nWr = 3'd1;
      4'h3: f.nRd = 3'd2;
      4'h4: f.hasAddr = 1'b1;
      4'h5: begin f.hasAddr = 1'b1; f.nWr = 3'd1; end
      4'h6: begin f.hasAddr = 1'b1; f.nWr = 3'd4; end
      4'h7: begin f.hasAddr = 1'b1; f.dummy = 1'b1; f.nRd = 3'd4; end
      4'h8: begin f.hasAddr = 1'b1; f.nRd = 3'd1; end
      4'h9: begin f.hasAddr = 1'b1; f.nRd = 3'd2; end
      4'hA: begin f.hasAddr = 1'b1; f.nRd = 3'd3; end
      4'hB: begin f.hasAddr = 1'b1; f.nRd = 3'd4; end
      default: f.valid = 1'b0;
    endcase
    return f;
  endfunction

  function automatic logic [3:0] headLen(input frameT f);
    return 4'd1 + (f.hasAddr ? 4'd3 : 4'd0) + {3'b000, f.dummy};
  endfunction

  function automatic logic [3:0] frameLen(input frameT f);
    return headLen(f) + {1'b0, f.nWr} + {1'b0, f.nRd};
  endfunction

  function automatic byteSelT selectByte(input frameT f, input logic [3:0] n);
    byteSelT s;
    logic [3:0] d;
    s = '{src: SRC_ZERO, idx: 2'd0, isRead: 1'b0};
    d = n - headLen(f);
    if (n == 4'd0) begin
      s.src = SRC_OPC;
    end else if (f.hasAddr && n <= 4'd3) begin
      case (n)
        4'd1:    s.src = SRC_AHI;
        4'd2:    s.src = SRC_AMID;
        default: s.src = SRC_ALO;
      endcase
    end else if (f.dummy && n == 4'd4) begin
      s.src = SRC_ZERO;
    end else begin
      s.idx = d[1:0];
      if (f.nRd != 3'd0) s.isRead = 1'b1;
      else               s.src = SRC_DATA;
    end
    return s;
  endfunction

endpackage

// File: rtl/spiSeqControl.sv
module spiSeqControl
  import spiSeqPkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrite,
  input  logic [3:0]       modeCode,
  input  logic [DIV_W-1:0] sckDiv,
  output dpCtrlT           ctl,
  output logic             busy,
  output logic             spiCsN,
  output logic             spiSck
);

  seqStateT         state;
  frameT            frame;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [2:0]       bitCnt;
  logic [3:0]       byteCnt;
  logic             sckR;
  logic             csNR;

  frameT   newFrame;
  byteSelT curSel, nxtSel, firstSel;
  logic    tick, lastByte, launchOk;

  always_comb begin
    newFrame = decodeMode(modeCode);
    firstSel = selectByte(newFrame, 4'd0);
    curSel   = selectByte(frame, byteCnt);
    nxtSel   = selectByte(frame, byteCnt + 4'd1);
    tick     = (divCnt == divLat);
    lastByte = ((byteCnt + 4'd1) == frameLen(frame));
    launchOk = modeWrite && (state == ST_IDLE) && newFrame.valid;

    ctl = '0;
    if (launchOk) begin
      ctl.launch  = 1'b1;
      ctl.load    = 1'b1;
      ctl.src     = firstSel.src;
      ctl.dataIdx = firstSel.idx;
    end
    if (state == ST_SHIFT && tick) begin
      if (!sckR) begin
        ctl.sample = 1'b1;
      end else begin
        ctl.shift = 1'b1;
        if (bitCnt == 3'd7) begin
          if (curSel.isRead) begin
            ctl.store    = 1'b1;
            ctl.storeIdx = curSel.idx;
          end
          if (!lastByte) begin
            ctl.load    = 1'b1;
            ctl.src     = nxtSel.src;
            ctl.dataIdx = nxtSel.idx;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      frame   <= '0;
      divCnt  <= '0;
      divLat  <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      sckR    <= 1'b0;
      csNR    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launchOk) begin
            state   <= ST_SHIFT;
            frame   <= newFrame;
            divLat  <= sckDiv;
            divCnt  <= '0;
            bitCnt  <= '0;
            byteCnt <= '0;
            sckR    <= 1'b0;
            csNR    <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            sckR   <= !sckR;
            if (sckR) begin
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) begin
                if (lastByte) state <= ST_TAIL;
                else          byteCnt <= byteCnt + 4'd1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            state  <= ST_IDLE;
            csNR   <= 1'b1;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign spiCsN = csNR;
  assign spiSck = sckR;

endmodule

// File: rtl/spiSeqDatapath.sv
module spiSeqDatapath
  import spiSeqPkg::*;
#(
  parameter int HOST_AW    = 3,
  parameter int DATA_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [7:0]         hostWdata,
  input  logic               busy,
  input  dpCtrlT             ctl,
  input  logic               spiMiso,
  output logic [7:0]         hostRdata,
  output logic               spiMosi
);

  localparam int DATA_IW  = $clog2(DATA_BYTES);
  localparam int OFF_OPC  = 0;
  localparam int OFF_MODE = 1;
  localparam int OFF_AMID = 2;
  localparam int OFF_ALO  = 3;
  localparam int OFF_DATA = 4;

  logic [7:0] opcodeR, addrMidR, addrLoR, shReg, nextByte;
  logic [3:0] addrHiR;
  logic       rxBit;
  logic [7:0] dataR [DATA_BYTES];

  logic               cfgWe;
  logic [DATA_IW-1:0] regIdx;

  assign cfgWe  = hostWe && !busy;
  assign regIdx = DATA_IW'(hostAddr - HOST_AW'(OFF_DATA));

  always_comb begin
    case (ctl.src)
      SRC_OPC:  nextByte = opcodeR;
      SRC_AHI:  nextByte = {4'h0, addrHiR};
      SRC_AMID: nextByte = addrMidR;
      SRC_ALO:  nextByte = addrLoR;
      SRC_DATA: nextByte = dataR[DATA_IW'(ctl.dataIdx)];
      default:  nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeR  <= '0;
      addrHiR  <= '0;
      addrMidR <= '0;
      addrLoR  <= '0;
      shReg    <= '0;
      rxBit    <= 1'b0;
      for (int i = 0; i < DATA_BYTES; i++) dataR[i] <= '0;
    end else begin
      if (cfgWe) begin
        case (int'(hostAddr))
          OFF_OPC:  opcodeR  <= hostWdata;
          OFF_MODE: ;
          OFF_AMID: addrMidR <= hostWdata;
          OFF_ALO:  addrLoR  <= hostWdata;
          default:  dataR[regIdx] <= hostWdata;
        endcase
      end
      if (ctl.launch) addrHiR <= hostWdata[3:0];
      if (ctl.store)  dataR[DATA_IW'(ctl.storeIdx)] <= {shReg[6:0], rxBit};
      if (ctl.sample) rxBit <= spiMiso;
      if (ctl.load)        shReg <= nextByte;
      else if (ctl.shift)  shReg <= {shReg[6:0], rxBit};
    end
  end

  always_comb begin
    case (int'(hostAddr))
      OFF_OPC:  hostRdata = opcodeR;
      OFF_MODE: hostRdata = {busy, 3'b000, addrHiR};
      OFF_AMID: hostRdata = addrMidR;
      OFF_ALO:  hostRdata = addrLoR;
      default:  hostRdata = dataR[regIdx];
    endcase
  end

  assign spiMosi = shReg[7];

endmodule

// File: rtl/spiFlashSeq.sv
module spiFlashSeq
  import spiSeqPkg::*;
#(
  parameter int DIV_W      = 4,
  parameter int HOST_AW    = 3,
  parameter int DATA_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   sckDiv,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  output logic               spiCsN,
  output logic               spiSck,
  output logic               spiMosi,
  input  logic               spiMiso
);

  localparam logic [HOST_AW-1:0] MODE_OFF = HOST_AW'(1);

  dpCtrlT ctl;
  logic   busy;
  logic   modeWrite;

  assign modeWrite = hostWe && (hostAddr == MODE_OFF);

  spiSeqControl #(.DIV_W(DIV_W)) control (
    .clk      (clk),
    .rstN     (rstN),
    .modeWrite(modeWrite),
    .modeCode (hostWdata[7:4]),
    .sckDiv   (sckDiv),
    .ctl      (ctl),
    .busy     (busy),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck)
  );

  spiSeqDatapath #(.HOST_AW(HOST_AW), .DATA_BYTES(DATA_BYTES)) datapath (
    .clk      (clk),
    .rstN     (rstN),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .busy     (busy),
    .ctl      (ctl),
    .spiMiso  (spiMiso),
    .hostRdata(hostRdata),
    .spiMosi  (spiMosi)
  );

endmodule

// File: rtl/spiSeqChecker.sv
module spiSeqChecker #(
  parameter int HOST_AW = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [7:0]         hostWdata,
  input logic               busy,
  input logic               spiCsN,
  input logic               spiSck
);

  logic modeWr, goodCode;
  assign modeWr   = hostWe && (hostAddr == HOST_AW'(1));
  assign goodCode = (hostWdata[7:4] != 4'h0) && (hostWdata[7:4] <= 4'hB);

  // R7
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  // R7
  cs_rise_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> !$past(spiSck));

  // R3
  launch_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !busy && goodCode) |=> (!spiCsN && busy));

  // R4
  bad_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !busy && !goodCode) |=> (spiCsN && !busy));

  // R9
  cs_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == !spiCsN);

  // R5
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeWr) |=> (!spiCsN || $rose(spiCsN)));

endmodule

bind spiFlashSeq spiSeqChecker #(.HOST_AW(HOST_AW)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWe   (hostWe),
  .hostAddr (hostAddr),
  .hostWdata(hostWdata),
  .busy     (busy),
  .spiCsN   (spiCsN),
  .spiSck   (spiSck)
);

// File: tb/spiFlashSeq_test.sv
`timescale 1ns/1ps
module spiFlashSeq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] sckDiv = '0;
  logic       hostWe = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       spiCsN, spiSck, spiMosi, spiMiso;

  int totalChk = 0;
  int badChk = 0;

  always #2.5 clk = ~clk;

  spiFlashSeq uut (
    .clk(clk), .rstN(rstN), .sckDiv(sckDiv), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // flash model
  logic [7:0] resp [16];
  logic [7:0] got  [16];
  logic [7:0] rBits = '0;
  int csFalls = 0;
  int sckNoCs = 0;

  assign spiMiso = resp[rBits[6:3]][3'd7 - rBits[2:0]];

  always @(negedge spiCsN) begin
    rBits = '0;
    csFalls++;
  end

  always @(posedge spiSck) begin
    if (spiCsN) sckNoCs++;
    got[rBits[6:3]] = {got[rBits[6:3]][6:0], spiMosi};
    rBits = rBits + 8'd1;
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", totalChk, badChk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    totalChk++;
    if (act != exp) begin
      badChk++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic layout(input int code, output int ha, output int dm,
                        output int nw, output int nr);
    ha = (code >= 4) ? 1 : 0;
    dm = (code == 7) ? 1 : 0;
    nw = (code == 2 || code == 5) ? 1 : (code == 6) ? 4 : 0;
    nr = (code == 3) ? 2 : (code == 7) ? 4 : (code >= 8) ? code - 7 : 0;
  endtask

  function automatic int busyCycles(input int n, input int dv);
    return (16 * n + 1) * (dv + 1);
  endfunction

  task automatic waitIdle(output int cnt);
    logic [7:0] v;
    cnt = 0;
    regRd(3'd1, v);
    while (v[7] && cnt < 5000) begin
      cnt++;
      @(negedge clk);
      regRd(3'd1, v);
    end
  endtask

  task automatic runFrame(input int code, input int dv, input logic [3:0] ahi,
                          input logic [7:0] opc, input logic [7:0] mid,
                          input logic [7:0] lo);
    logic [7:0] dat [4];
    logic [7:0] exp [16];
    logic [7:0] v;
    int ha, dm, nw, nr, pre, n, cnt, falls0;
    layout(code, ha, dm, nw, nr);
    pre = 1 + 3 * ha + dm;
    n = pre + nw + nr;
    for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
    for (int i = 0; i < 16; i++) resp[i] = 8'($urandom);
    @(negedge clk);
    sckDiv = 4'(dv);
    regWr(3'd0, opc);
    regWr(3'd2, mid);
    regWr(3'd3, lo);
    for (int i = 0; i < 4; i++) regWr(3'(4 + i), dat[i]);
    regRd(3'd0, v);
    chk("R2 opcode readback", v, opc);
    regRd(3'd3, v);
    chk("R2 addr low readback", v, lo);
    falls0 = csFalls;
    regWr(3'd1, {4'(code), ahi});
    chk("R3 cs low after launch", spiCsN, 0);
    waitIdle(cnt);
    chk($sformatf("R9 busy cycles code %0d div %0d", code, dv), cnt, busyCycles(n, dv));
    chk("R3 one frame started", csFalls - falls0, 1);
    chk("R6 bit count", rBits, 8 * n);
    exp[0] = opc;
    exp[1] = {4'h0, ahi}; exp[2] = mid; exp[3] = lo; exp[4] = 8'h00;
    for (int i = 0; i < nw; i++) exp[pre + i] = dat[i];
    for (int i = 0; i < nr; i++) exp[pre + i] = 8'h00;
    for (int k = 0; k < n; k++)
      chk($sformatf("R6 code %0d byte %0d", code, k), got[k], exp[k]);
    for (int i = 0; i < 4; i++) begin
      regRd(3'(4 + i), v);
      chk($sformatf("R8 code %0d data %0d", code, i), v,
          (i < nr) ? resp[pre + i] : dat[i]);
    end
    regRd(3'd1, v);
    chk("R2 mode readback", v, {4'h0, ahi});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    totalChk++;
    badChk++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt, f0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csN", spiCsN, 1);
    chk("R1 sck", spiSck, 0);
    for (int a = 0; a < 8; a++) begin
      regRd(3'(a), v);
      chk($sformatf("R1 offset %0d", a), v, 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // every layout
    for (int c = 1; c <= 11; c++)
      runFrame(c, c % 2, 4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    // longest frame at full speed: 145 cycles
    runFrame(7, 0, 4'hF, 8'h0B, 8'hFF, 8'hFF);

    // random frames
    for (int t = 0; t < 40; t++)
      runFrame(1 + int'($urandom % 11), int'($urandom % 4), 4'($urandom),
               8'($urandom), 8'($urandom), 8'($urandom));

    // R4: illegal codes
    regWr(3'd1, 8'h43);
    waitIdle(cnt);
    f0 = csFalls;
    regWr(3'd1, 8'h05);
    regWr(3'd1, 8'hDA);
    regWr(3'd1, 8'hF9);
    repeat (20) @(negedge clk);
    chk("R4 no frame on illegal code", csFalls - f0, 0);
    regRd(3'd1, v);
    chk("R4 mode readback kept", v, 8'h03);

    // R5: writes during a frame are dropped
    @(negedge clk);
    sckDiv = 4'd2;
    regWr(3'd4, 8'h5A);
    f0 = csFalls;
    regWr(3'd1, 8'h67);
    regWr(3'd4, 8'hA5);
    regWr(3'd1, 8'h1C);
    regWr(3'd0, 8'h77);
    waitIdle(cnt);
    repeat (20) @(negedge clk);
    chk("R5 single frame", csFalls - f0, 1);
    regRd(3'd4, v);
    chk("R5 data write dropped", v, 8'h5A);
    regRd(3'd1, v);
    chk("R5 mode write dropped", v, 8'h07);
    chk("R7 sck only with cs low", sckNoCs, 0);

    report();
    $finish;
  end

endmodule